// File: doc/BRIEF.md
# Peripheral Interrupt Status and Enable Register Block

This block sits inside a peripheral, between the single-cycle event pulses the peripheral raises and one level-sensitive interrupt request toward the chip's top-level interrupt controller. Every event pulse sets a sticky bit in a pending register. A separate enable register chooses which pending bits may drive the request line. Pending bits are latched whether or not they are enabled.

Software reaches the block through a small memory-mapped register port. It has a write strobe, a read strobe, a byte address and 32-bit data. A handler can read either the raw pending word or a pre-masked view. To acknowledge, it writes the word it read back to the pending address: each 1 clears its bit, and each 0 leaves its bit alone. The request line is registered. It follows the pending and enable state that exists after each clock edge, so it rises in the same edge that latches an enabled event.

The block has no internal sequencing. There is no state machine, and no request state exists apart from the pending and enable registers. Register selection is decoded into one of four named selections: none, enable, masked view, or pending.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset the pending register, the enable register, the read data and the request line are all 0.
- R2: A 1 on event bit i during a clock edge sets pending bit i at that edge, and the bit stays set until it is acknowledged.
- R3: Pending bits latch regardless of their enable bit. Setting the enable bit of an already pending bit raises the request line at the edge that writes the enable register.
- R4: A write to offset 0x0 loads the enable register from the low NSRC bits of the write data, and a read of 0x0 returns it.
- R5: A read of offset 0x4 returns pending AND enable. Writes to 0x4 change neither register.
- R6: A write to offset 0x8 clears each pending bit whose write-data bit is 1, and leaves the bits whose write-data bit is 0 untouched. A read of 0x8 returns the raw pending register.
- R7: When an event and an acknowledge hit the same bit at the same edge, the bit stays set.
- R8: The request line is 1 exactly when some pending bit and its enable bit are both 1. It updates at the same clock edge as those registers.
- R9: Read data is registered, so it appears one cycle after the read strobe. Any other address (for example 0xC) reads 0 and ignores writes. Bits at and above NSRC read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The latching path is tried in three ways: with the source disabled, with it enabled, and with several sources arriving together under a partial enable. These separate a pending latch that depends on the enable bit from one that does not, and a masked view that is computed from a stale value. Acknowledge writes carry all-zero words, single bits and mixed words, which tell a true write-one-to-clear apart from a plain overwrite of the register. The collision of an event with the acknowledge of the same bit shows which of the two takes priority. Writes to the read-only and unmapped offsets, and an all-ones enable word, show that those writes do not leak into any register.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [7:0] OFS_ENABLE = 8'h00;
    localparam logic [7:0] OFS_MASKED = 8'h04;
    localparam logic [7:0] OFS_STATUS = 8'h08;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_MASKED = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output reg_sel_e          sel,
    output logic              we_enable,
    output logic              we_ack
);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASKED);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_STATUS);

    always_comb begin
        if (addr == A_EN)       sel = SEL_ENABLE;
        else if (addr == A_MSK) sel = SEL_MASKED;
        else if (addr == A_ST)  sel = SEL_STATUS;
        else                    sel = SEL_NONE;
    end

    always_comb begin
        we_enable = 1'b0;
        we_ack    = 1'b0;
        unique case (sel)
            SEL_ENABLE: we_enable = wr_en;
            SEL_STATUS: we_ack    = wr_en;
            SEL_MASKED,
            SEL_NONE:   ;
        endcase
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            ack_we,
    input  logic [NSRC-1:0] ack_bits,
    output logic [NSRC-1:0] status_q,
    output logic [NSRC-1:0] status_nxt
);
    logic [NSRC-1:0] clr;
    assign clr = ack_we ? ack_bits : '0;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // an event outranks a clear of the same bit
        always_comb status_nxt[i] = evt_i[i] | (status_q[i] & ~clr[i]);

        always_ff @(posedge clk) begin
            if (!rst_n) status_q[i] <= 1'b0;
            else        status_q[i] <= status_nxt[i];
        end

        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> status_q[i]);
        assert_bit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !clr[i]) |=> status_q[i]);
        assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt_i[i]) |=> !status_q[i]);
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && evt_i[i]) |=> status_q[i]);
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] en_nxt
);
    always_comb en_nxt = we ? wbits : en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_nxt;
    end

    assert_en_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (en_q == $past(wbits)));
    assert_en_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en_q));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_regs_pkg::*;
#(
    parameter int unsigned NSRC   = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_o
);
    reg_sel_e        sel;
    logic            we_enable;
    logic            we_ack;
    logic [NSRC-1:0] status_q, status_nxt;
    logic [NSRC-1:0] en_q, en_nxt;
    logic [DATA_W-1:0] rd_word;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (addr),
        .wr_en     (wr_en),
        .sel       (sel),
        .we_enable (we_enable),
        .we_ack    (we_ack)
    );

    irq_status_bank #(.NSRC(NSRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .ack_we     (we_ack),
        .ack_bits   (wdata[NSRC-1:0]),
        .status_q   (status_q),
        .status_nxt (status_nxt)
    );

    irq_enable_reg #(.NSRC(NSRC)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we_enable),
        .wbits  (wdata[NSRC-1:0]),
        .en_q   (en_q),
        .en_nxt (en_nxt)
    );

    // request registered from next-state values: same-edge response
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(status_nxt & en_nxt);
    end

    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_ENABLE: rd_word = DATA_W'(en_q);
            SEL_MASKED: rd_word = DATA_W'(status_q & en_q);
            SEL_STATUS: rd_word = DATA_W'(status_q);
            SEL_NONE:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    assert_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_q & en_q));
    assert_masked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_MASKED) |=> (rdata == DATA_W'($past(status_q & en_q))));
    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: tb/irq_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_regs_tb_top;
    localparam int NSRC = 16;
    localparam logic [7:0] A_EN = 8'h00, A_MSK = 8'h04, A_ST = 8'h08, A_BAD = 8'h0C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic irq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_ctrl_regs #(.NSRC(NSRC), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk); evt_i = m;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rdata", rdata, 0);
        check("R1 irq", {31'd0, irq_o}, 0);
        do_read(A_EN, v);  check("R1 enable", v, 0);
        do_read(A_ST, v);  check("R1 status", v, 0);
        do_read(A_MSK, v); check("R1 masked", v, 0);
    endtask

    task automatic t_latch_then_enable();
        logic [31:0] v;
        pulse(16'h0008);
        check("R3 irq while disabled", {31'd0, irq_o}, 0);
        do_read(A_ST, v);  check("R2 status latched", v, 32'h8);
        do_read(A_MSK, v); check("R5 masked disabled", v, 0);
        repeat (3) @(negedge clk);
        do_read(A_ST, v);  check("R2 status held", v, 32'h8);
        do_write(A_EN, 32'h8);
        check("R3 irq on late enable", {31'd0, irq_o}, 1);
        do_read(A_EN, v);  check("R4 enable readback", v, 32'h8);
        do_read(A_MSK, v); check("R5 masked", v, 32'h8);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        do_write(A_ST, 32'h0);
        do_read(A_ST, v);  check("R6 zero write no effect", v, 32'h8);
        check("R8 irq still high", {31'd0, irq_o}, 1);
        do_write(A_ST, 32'h8);
        check("R8 irq drops on ack", {31'd0, irq_o}, 0);
        do_read(A_ST, v);  check("R6 ack cleared", v, 0);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        pulse(16'h0005);
        check("R8 irq unenabled sources", {31'd0, irq_o}, 0);
        pulse(16'h0008);
        check("R8 irq enabled source", {31'd0, irq_o}, 1);
        do_read(A_ST, v);  check("R2 multi status", v, 32'hD);
        do_read(A_MSK, v); check("R5 multi masked", v, 32'h8);
        do_write(A_ST, 32'h1);
        do_read(A_ST, v);  check("R6 partial ack", v, 32'hC);
        check("R8 irq after partial ack", {31'd0, irq_o}, 1);
        do_write(A_ST, 32'h8);
        check("R8 irq after enabled ack", {31'd0, irq_o}, 0);
        do_read(A_ST, v);  check("R6 remaining bit", v, 32'h4);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk); evt_i = 16'h0004; wr_en = 1'b1; addr = A_ST; wdata = 32'h4;
        @(negedge clk); evt_i = '0; wr_en = 1'b0;
        do_read(A_ST, v);  check("R7 set wins over ack", v, 32'h4);
        do_write(A_ST, 32'h4);
        do_read(A_ST, v);  check("R7 later ack clears", v, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        pulse(16'h0002);
        do_write(A_MSK, 32'hFFFF_FFFF);
        do_read(A_EN, v);  check("R5 masked write ignored (enable)", v, 32'h8);
        do_read(A_ST, v);  check("R5 masked write ignored (status)", v, 32'h2);
        do_write(A_BAD, 32'hFFFF_FFFF);
        do_read(A_EN, v);  check("R9 unmapped write ignored (enable)", v, 32'h8);
        do_read(A_ST, v);  check("R9 unmapped write ignored (status)", v, 32'h2);
        do_read(A_BAD, v); check("R9 unmapped read zero", v, 0);
        do_write(A_EN, 32'hFFFF_FFFF);
        check("R3 irq on enable of pending", {31'd0, irq_o}, 1);
        do_read(A_EN, v);  check("R9 upper bits zero", v, 32'h0000_FFFF);
        do_write(A_EN, 32'h0);
        check("R8 irq off after disable", {31'd0, irq_o}, 0);
        do_read(A_ST, v);  check("R3 pending survives disable", v, 32'h2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_then_enable();
        t_ack();
        t_multi();
        t_collision();
        t_ignored();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule